// File: doc/BRIEF.md
# Floating-Point Operation Sequencer

This block handles the start and completion handshake of a multi-cycle floating-point unit. It watches a level-held `enable` input. On the first cycle that input is seen high after being low, it captures both operands, the operation code and the rounding mode. It then sends a one-cycle start pulse to the arithmetic datapath and times a completion latency chosen by the operation. When that latency has run out, it copies the datapath's result and exception flags into output registers and raises `ready`.

The datapath is outside this block. The sequencer feeds it the captured values and samples its result only in the completion cycle, so the datapath may change its outputs freely while it works. Operation codes with no operation behind them are never passed to the datapath. They finish after a short fixed latency, with a quiet NaN as the result and the invalid flag set.

A caller starts an operation by raising `enable`, holding it for a couple of cycles and dropping it. It must release `enable` and raise it again before each new operation. A new start that arrives while an operation is still running abandons that operation and begins the new one.

Top module: `fpseq_ctrl`

## Requirements
- R1: When `rst_n` is low at a clock edge, `ready`, `result`, `flags` and `dp_start` are all 0 after that edge.
- R2: A start is a clock edge at which `enable` is 1 and was 0 at the previous edge. Keeping `enable` high on later edges does not start again.
- R3: At the start edge, `opa`, `opb`, `op` and `rmode` are captured onto `dp_opa`, `dp_opb`, `dp_op` and `dp_rmode`. Changes to those inputs after the start edge have no effect on the operation or its result.
- R4: `ready` is 0 after every start edge. Once set, it stays 1 until the next start edge.
- R5: Opcode encoding: 0 = add, 1 = subtract, 2 = multiply, 3 = divide. `ready` rises exactly LAT_ADD, LAT_SUB, LAT_MUL or LAT_DIV edges after the start edge (defaults 20, 21, 24 and 71).
- R6: For opcodes 0 to 3, `dp_start` is 1 for exactly the one cycle after the start edge.
- R7: When `ready` rises after a valid opcode, `result` and `flags` hold the values `dp_result` and `dp_flags` had at the completion edge.
- R8: Opcodes 4 to 7 produce no `dp_start` pulse. `ready` rises LAT_BAD edges after the start edge (default 3). `result` is then the quiet NaN: sign 0, exponent all ones, top mantissa bit 1 and the rest 0 (0x7FF8000000000000 at the default widths). `flags` is 5'b00001.
- R9: Flag bit positions: bit 4 underflow, bit 3 overflow, bit 2 inexact, bit 1 exception, bit 0 invalid.
- R10: A start edge while an operation is still running abandons that operation. Only the new one completes, and `ready` stays 0 until it does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Level-held start request |
| op | input | 3 | Operation code |
| rmode | input | 2 | Rounding mode, passed through to the datapath |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| dp_start | output | 1 | One-cycle start pulse to the datapath |
| dp_op | output | 3 | Captured operation code |
| dp_rmode | output | 2 | Captured rounding mode |
| dp_opa | output | W | Captured first operand |
| dp_opb | output | W | Captured second operand |
| dp_result | input | W | Datapath result |
| dp_flags | input | 5 | Datapath exception flags |
| result | output | W | Registered result |
| flags | output | 5 | Registered flags |
| ready | output | 1 | Result valid |

## Verification
The bench builds the block with its default parameters: 64-bit operands and latencies of 20, 21, 24, 71 and 3. This brings the longest timing window, the 71-cycle divide, into every run. The stub datapath computes a fixed function of the captured operands. Because the bench scrambles the live inputs right after each start, any capture or hold fault shows up in the result. Varied enable hold lengths, abandoned operations and unused opcodes exercise the edge detector, the restart path and the NaN path.

// File: rtl/fpseq_pkg.sv
// Shared constants of the floating-point operation sequencer.
// Assumes opcodes 0..3 are implemented and 4..7 are not.
package fpseq_pkg;
    localparam int OP_W    = 3;
    localparam int RM_W    = 2;
    localparam int FLAG_W  = 5;

    localparam logic [OP_W-1:0] OP_ADD = 3'd0;
    localparam logic [OP_W-1:0] OP_SUB = 3'd1;
    localparam logic [OP_W-1:0] OP_MUL = 3'd2;
    localparam logic [OP_W-1:0] OP_DIV = 3'd3;

    // Flag bit positions
    localparam int FL_INVALID   = 0;
    localparam int FL_EXCEPTION = 1;
    localparam int FL_INEXACT   = 2;
    localparam int FL_OVERFLOW  = 3;
    localparam int FL_UNDERFLOW = 4;

    // True for opcodes that have a datapath behind them
    function automatic logic op_known(input logic [OP_W-1:0] code);
        return code <= OP_DIV;
    endfunction
endpackage

// File: rtl/fpseq_edge.sv
// Start detector: flags the first edge at which enable is seen high
// after having been low. Assumes enable is synchronous to clk.
module fpseq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic launch
);
    logic en_q;

    // Remember enable from the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= enable;
    end

    assign launch = enable & ~en_q;
endmodule

// File: rtl/fpseq_timer.sv
// Latency timer: loads the latency of the launched opcode and signals
// done in the cycle whose edge completes it. Assumes every latency >= 1.
// A launch during a running count reloads it.
module fpseq_timer #(
    parameter int LAT_ADD = 20,
    parameter int LAT_SUB = 21,
    parameter int LAT_MUL = 24,
    parameter int LAT_DIV = 71,
    parameter int LAT_BAD = 3,
    parameter int CNT_W   = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      launch,
    input  logic [fpseq_pkg::OP_W-1:0] op,
    output logic                      done
);
    import fpseq_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lat;
    logic             busy;

    // Latency lookup for the opcode being launched
    always_comb begin
        case (op)
            OP_ADD:  lat = CNT_W'(LAT_ADD);
            OP_SUB:  lat = CNT_W'(LAT_SUB);
            OP_MUL:  lat = CNT_W'(LAT_MUL);
            OP_DIV:  lat = CNT_W'(LAT_DIV);
            default: lat = CNT_W'(LAT_BAD);
        endcase
    end

    // Down-counter with busy marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (launch) begin
            cnt  <= lat - CNT_W'(1);
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - CNT_W'(1);
        end
    end

    assign done = busy && (cnt == '0) && !launch;
endmodule

// File: rtl/fpseq_outreg.sv
// Output register: clears ready on launch and, on done, latches either
// the datapath result and flags or the quiet-NaN/invalid pair for an
// unknown opcode. Assumes launch and done are never high together.
module fpseq_outreg #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         launch,
    input  logic                         done,
    input  logic                         bad_op,
    input  logic [W-1:0]                 dp_result,
    input  logic [fpseq_pkg::FLAG_W-1:0] dp_flags,
    output logic [W-1:0]                 result,
    output logic [fpseq_pkg::FLAG_W-1:0] flags,
    output logic                         ready
);
    import fpseq_pkg::*;

    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [FLAG_W-1:0] INV_ONLY = FLAG_W'(1) << FL_INVALID;

    // Result, flags and ready registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            flags  <= '0;
            ready  <= 1'b0;
        end else if (launch) begin
            ready  <= 1'b0;
        end else if (done) begin
            ready  <= 1'b1;
            result <= bad_op ? QNAN : dp_result;
            flags  <= bad_op ? INV_ONLY : dp_flags;
        end
    end
endmodule

// File: rtl/fpseq_ctrl.sv
// Floating-point operation sequencer top. Captures the request on a
// start edge, pulses the datapath, times the completion and registers
// the outcome. Assumes the datapath holds its result stable at the
// completion edge.
module fpseq_ctrl #(
    parameter int EXP_W   = 11,
    parameter int MAN_W   = 52,
    parameter int LAT_ADD = 20,
    parameter int LAT_SUB = 21,
    parameter int LAT_MUL = 24,
    parameter int LAT_DIV = 71,
    parameter int LAT_BAD = 3,
    localparam int W      = 1 + EXP_W + MAN_W,
    localparam int LAT_MAX = (LAT_DIV > LAT_MUL) ? LAT_DIV : LAT_MUL,
    localparam int CNT_W  = $clog2(LAT_MAX + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enable,
    input  logic [fpseq_pkg::OP_W-1:0]   op,
    input  logic [fpseq_pkg::RM_W-1:0]   rmode,
    input  logic [W-1:0]                 opa,
    input  logic [W-1:0]                 opb,
    output logic                         dp_start,
    output logic [fpseq_pkg::OP_W-1:0]   dp_op,
    output logic [fpseq_pkg::RM_W-1:0]   dp_rmode,
    output logic [W-1:0]                 dp_opa,
    output logic [W-1:0]                 dp_opb,
    input  logic [W-1:0]                 dp_result,
    input  logic [fpseq_pkg::FLAG_W-1:0] dp_flags,
    output logic [W-1:0]                 result,
    output logic [fpseq_pkg::FLAG_W-1:0] flags,
    output logic                         ready
);
    import fpseq_pkg::*;

    logic launch;
    logic done;
    logic bad_q;

    fpseq_edge i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .launch (launch)
    );

    // Request capture and datapath start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_op    <= '0;
            dp_rmode <= '0;
            dp_opa   <= '0;
            dp_opb   <= '0;
            bad_q    <= 1'b0;
            dp_start <= 1'b0;
        end else begin
            dp_start <= launch && op_known(op);
            if (launch) begin
                dp_op    <= op;
                dp_rmode <= rmode;
                dp_opa   <= opa;
                dp_opb   <= opb;
                bad_q    <= !op_known(op);
            end
        end
    end

    fpseq_timer #(
        .LAT_ADD (LAT_ADD),
        .LAT_SUB (LAT_SUB),
        .LAT_MUL (LAT_MUL),
        .LAT_DIV (LAT_DIV),
        .LAT_BAD (LAT_BAD),
        .CNT_W   (CNT_W)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .op     (op),
        .done   (done)
    );

    fpseq_outreg #(
        .EXP_W (EXP_W),
        .MAN_W (MAN_W)
    ) i_outreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .done      (done),
        .bad_op    (bad_q),
        .dp_result (dp_result),
        .dp_flags  (dp_flags),
        .result    (result),
        .flags     (flags),
        .ready     (ready)
    );
endmodule

// File: rtl/fpseq_ctrl_chk.sv
// Assertion checker for fpseq_ctrl, attached by bind. Counts cycles
// since each start to check the completion window.
module fpseq_ctrl_chk #(
    parameter int EXP_W   = 11,
    parameter int MAN_W   = 52,
    parameter int LAT_ADD = 20,
    parameter int LAT_SUB = 21,
    parameter int LAT_MUL = 24,
    parameter int LAT_DIV = 71,
    parameter int LAT_BAD = 3,
    localparam int W      = 1 + EXP_W + MAN_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         launch,
    input logic         done,
    input logic         dp_start,
    input logic [2:0]   dp_op,
    input logic [W-1:0] dp_opa,
    input logic [W-1:0] dp_opb,
    input logic [W-1:0] result,
    input logic [4:0]   flags,
    input logic         ready
);
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic [7:0] since;
    int         exp_lat;

    // Cycles elapsed since the latest start edge, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)             since <= '0;
        else if (launch)        since <= 8'd1;
        else if (since != 8'hFF) since <= since + 8'd1;
    end

    // Expected latency of the captured opcode
    always_comb begin
        case (dp_op)
            3'd0:    exp_lat = LAT_ADD;
            3'd1:    exp_lat = LAT_SUB;
            3'd2:    exp_lat = LAT_MUL;
            3'd3:    exp_lat = LAT_DIV;
            default: exp_lat = LAT_BAD;
        endcase
    end

    a_r4_ready_clears: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !ready);
    a_r4_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !launch) |=> ready);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dp_start |=> !dp_start);
    a_r8_no_start_bad: assert property (@(posedge clk) disable iff (!rst_n)
        dp_start |-> dp_op <= 3'd3);
    a_r3_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> ($stable(dp_opa) && $stable(dp_opb) && $stable(dp_op)));
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(since) == exp_lat));
    a_r8_qnan: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dp_op > 3'd3) |=> (result == QNAN && flags == 5'b00001));
endmodule

bind fpseq_ctrl fpseq_ctrl_chk #(
    .EXP_W   (EXP_W),
    .MAN_W   (MAN_W),
    .LAT_ADD (LAT_ADD),
    .LAT_SUB (LAT_SUB),
    .LAT_MUL (LAT_MUL),
    .LAT_DIV (LAT_DIV),
    .LAT_BAD (LAT_BAD)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .done     (done),
    .dp_start (dp_start),
    .dp_op    (dp_op),
    .dp_opa   (dp_opa),
    .dp_opb   (dp_opb),
    .result   (result),
    .flags    (flags),
    .ready    (ready)
);

// File: tb/test_fpseq_ctrl.sv
// Scoreboard bench for fpseq_ctrl with a stub datapath.
module test_fpseq_ctrl;
    localparam int W = 64;
    localparam logic [W-1:0] QNAN = 64'h7FF8_0000_0000_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic [2:0]   op = '0;
    logic [1:0]   rmode = '0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         dp_start;
    logic [2:0]   dp_op;
    logic [1:0]   dp_rmode;
    logic [W-1:0] dp_opa, dp_opb;
    logic [W-1:0] dp_result;
    logic [4:0]   dp_flags;
    logic [W-1:0] result;
    logic [4:0]   flags;
    logic         ready;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int starts = 0;
    int exp_starts = 0;
    logic rdy_prev = 1'b0;

    typedef struct {
        logic [W-1:0] res;
        logic [4:0]   flg;
        int           lat;
        int           t0;
        string        tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    // Stub datapath: fixed function of the captured request
    assign dp_result = dp_opa ^ {dp_opb[W-2:0], 1'b0} ^ {59'd0, dp_rmode, dp_op};
    assign dp_flags  = dp_opa[4:0] ^ dp_opb[4:0];

    fpseq_ctrl i_fpseq_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .op(op), .rmode(rmode),
        .opa(opa), .opb(opb), .dp_start(dp_start), .dp_op(dp_op),
        .dp_rmode(dp_rmode), .dp_opa(dp_opa), .dp_opb(dp_opb),
        .dp_result(dp_result), .dp_flags(dp_flags), .result(result),
        .flags(flags), .ready(ready)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int lat_of(input logic [2:0] c);
        case (c)
            3'd0: return 20;
            3'd1: return 21;
            3'd2: return 24;
            3'd3: return 71;
            default: return 3;
        endcase
    endfunction

    // Driver: issue one operation and push its expected outcome
    task automatic run_op(input logic [2:0] c, input logic [1:0] rm,
                          input logic [W-1:0] a, input logic [W-1:0] b,
                          input int hold, input string tag);
        item_t it;
        @(negedge clk);
        it.t0 = cyc;
        op = c; rmode = rm; opa = a; opb = b; enable = 1'b1;
        if (c <= 3'd3) begin
            it.res = a ^ {b[W-2:0], 1'b0} ^ {59'd0, rm, c};
            it.flg = a[4:0] ^ b[4:0];
            exp_starts++;
        end else begin
            it.res = QNAN;
            it.flg = 5'b00001;
        end
        it.lat = lat_of(c);
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        check(ready == 1'b0, "R4 ready low after start", 64'(ready), 64'd0);
        // R3: scramble live inputs after the start edge
        op = ~c; rmode = ~rm; opa = ~a; opb = a ^ b;
        repeat (hold - 1) @(negedge clk);
        enable = 1'b0;
        while (!ready) @(negedge clk);
        repeat (3) @(negedge clk);
        check(ready == 1'b1, "R4 ready stays high", 64'(ready), 64'd1);
    endtask

    // Monitor: compare each completion against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (dp_start) starts++;
            if (ready && !rdy_prev) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10 unexpected completion", result, 64'd0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(result == it.res, {it.tag, " result"}, result, it.res);
                    check(flags == it.flg, {it.tag, " flags"}, 64'(flags), 64'(it.flg));
                    check(cyc - it.t0 - 1 == it.lat, {it.tag, " latency"},
                          64'(cyc - it.t0 - 1), 64'(it.lat));
                end
            end
            rdy_prev <= ready;
        end
    end

    // Watchdog
    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        enable = 1'b1;
        repeat (4) @(negedge clk);
        check(ready == 1'b0, "R1 reset ready", 64'(ready), 64'd0);
        check(result == '0, "R1 reset result", result, 64'd0);
        check(flags == '0 && dp_start == 1'b0, "R1 reset flags/start",
              64'(flags), 64'd0);
        enable = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_op(3'd0, 2'd0, 64'h3FF0_0000_0000_0001, 64'h4000_0000_0000_0013, 2, "R5 R7 R9 add");
        run_op(3'd1, 2'd1, 64'hC010_1234_5678_9ABC, 64'h0000_0000_0000_0007, 2, "R5 R7 sub");
        run_op(3'd2, 2'd2, 64'h7FEF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_001E, 2, "R5 R7 mul");
        run_op(3'd3, 2'd3, 64'h0000_0000_0000_0001, 64'hFFFF_0000_FFFF_0000, 2, "R5 R7 div");
        run_op(3'd5, 2'd0, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 2, "R8 unused op 5");
        run_op(3'd7, 2'd1, 64'hAAAA_5555_AAAA_5555, 64'h5555_AAAA_5555_AAAA, 2, "R8 unused op 7");
        // R2: enable held long does not retrigger
        run_op(3'd0, 2'd2, 64'h0123_4567_89AB_CDEF, 64'h1111_2222_3333_4444, 40, "R2 long hold");

        // R10: abandon a divide with a new start
        @(negedge clk);
        op = 3'd3; rmode = 2'd0; opa = 64'hDEAD; opb = 64'hBEEF; enable = 1'b1;
        exp_starts++;
        repeat (2) @(negedge clk);
        enable = 1'b0;
        repeat (10) @(negedge clk);
        run_op(3'd1, 2'd3, 64'h4008_0000_0000_0002, 64'h0000_0000_0000_0019, 2, "R10 restart");
        repeat (80) @(negedge clk);
        check(sb.size() == 0, "R10 no stale completion", 64'(sb.size()), 64'd0);
        check(starts == exp_starts, "R6 R8 start pulse count", 64'(starts), 64'(exp_starts));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule